// File: doc/BRIEF.md
# Serial Port Master Emulating an SPI Bus

This block is a synchronous serial master that presents an SPI-style bus to a slave device such as a serial flash. Once enabled, it runs a free-running serial clock derived from the system clock by a programmable divider, and it uses an internally generated, active-low frame sync as the chip-select. Because the slave ignores clock edges while chip-select is high, the clock can keep toggling between words without disturbing the slave.

Words arrive on a ready/valid transmit interface. Each word is shifted out most significant bit first on the data-out pin, with changes on the falling serial-clock edge. The frame sync drops in the same serial-clock cycle as the first data bit, with no lead bit period. The data-in pin is sampled on the rising edge of the same serial clock, and each received word comes back with a one-cycle valid strobe. When the next word is already waiting at the end of a word, the frame sync stays low and the words follow with no gap. With no word waiting, the frame sync returns high.

Top module: `spi_emu_master`

## Requirements
- R1: While `enable` is high, `sclk` toggles continuously, including when no word is in flight. Its period is 2*(`clk_div`+1) system clocks, so `clk_div`=0 gives half the system clock.
- R2: During reset and in every cycle after a cycle with `enable` low, `sclk`=1, `fs_n`=1, `mosi`=0, `tx_ready`=0 and `rx_valid`=0.
- R3: `fs_n` goes low only in the cycle where `sclk` falls. In that same cycle `mosi` carries bit WORD_W-1 of the word (late framing).
- R4: While enabled, `mosi` changes only in a cycle where `sclk` has just fallen. Words go out most significant bit first, one bit per serial-clock period.
- R5: `fs_n` stays low for exactly WORD_W serial-clock periods per word. With no next word accepted, it returns high on the falling `sclk` edge after the last bit, and `mosi` returns to 0.
- R6: If a word is accepted at the end of the current word, `fs_n` stays low and the next word's first bit follows on that falling edge with no gap.
- R7: A frame starts only after a word is accepted. Acceptance is `tx_valid`&&`tx_ready`. `tx_ready` is high only in the cycle just before a falling `sclk` edge, and only when the port is idle or on the last bit of a word.
- R8: `miso` is sampled on each rising `sclk` edge while `fs_n` is low. Sampled bits fill the word from the most significant bit down.
- R9: `rx_valid` is a single-cycle pulse in the cycle after the rising edge that samples a word's last bit, with `rx_data` holding that word and `fs_n` still low.
- R10: Dropping `enable` in the middle of a word aborts it. The outputs go idle as in R2 and no `rx_valid` is produced for the partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; low holds the port idle |
| clk_div | input | DIV_W | Serial clock divider; period is 2*(clk_div+1) clocks |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Port takes the word at this clock edge |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock, idle high |
| fs_n | output | 1 | Active-low frame sync used as chip-select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is the word boundary inside a continuous frame. A new word has to be offered exactly when the last bit finishes, so that the frame sync must stay low while the receiver posts its valid pulse. The stimulus gets there by holding `tx_valid` asserted across a batch of words at the fastest divider and at a middle setting. The bench counts frame-sync falling edges to show that several words share one frame. A mid-word disable covers the abort path, and isolated words with gaps cover the frame-end path.

// File: rtl/spi_emu_pkg.sv
package spi_emu_pkg;

  // One-cycle events from the clock generator: sclk falls / rises at the next edge
  typedef struct packed {
    logic fall;
    logic rise;
  } sclk_evt_t;

  // Serial clock period in system clocks for a given divider setting
  function automatic int unsigned sclk_period(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // Number of system clocks sclk holds each level
  function automatic int unsigned sclk_half(input int unsigned div);
    return sclk_period(div) / 2;
  endfunction

endpackage

// File: rtl/spi_emu_sclk_gen.sv
module spi_emu_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [DIV_W-1:0]       div,
  output logic                   sclk,
  output spi_emu_pkg::sclk_evt_t evt
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  // terminal count of the half period; >= keeps a live divider change safe
  assign wrap     = en && (cnt >= div);
  assign evt.fall = wrap && sclk;
  assign evt.rise = wrap && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.fall && evt.rise));

endmodule

// File: rtl/spi_emu_tx.sv
module spi_emu_tx #(
  parameter int WORD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  spi_emu_pkg::sclk_evt_t evt,
  input  logic [WORD_W-1:0]      tx_data,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  output logic                   mosi,
  output logic                   active,
  output logic                   last_bit
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic              take;

  assign last_bit = active && (bit_idx == LAST_IDX);
  assign tx_ready = en && evt.fall && (!active || last_bit);
  assign take     = tx_ready && tx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      shreg   <= '0;
      bit_idx <= '0;
      active  <= 1'b0;
      mosi    <= 1'b0;
    end else if (evt.fall) begin
      if (take) begin
        mosi    <= tx_data[WORD_W-1];
        shreg   <= {tx_data[WORD_W-2:0], 1'b0};
        bit_idx <= '0;
        active  <= 1'b1;
      end else if (!active || last_bit) begin
        mosi    <= 1'b0;
        bit_idx <= '0;
        active  <= 1'b0;
      end else begin
        mosi    <= shreg[WORD_W-1];
        shreg   <= {shreg[WORD_W-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  a_r7_take_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> active);

endmodule

// File: rtl/spi_emu_rx.sv
module spi_emu_rx #(
  parameter int WORD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  spi_emu_pkg::sclk_evt_t evt,
  input  logic                   active,
  input  logic                   last_bit,
  input  logic                   miso,
  output logic [WORD_W-1:0]      rx_data,
  output logic                   rx_valid
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;
  logic              capture;

  assign capture   = evt.rise && active;
  assign next_word = {shreg[WORD_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (capture) begin
        shreg <= next_word;
        if (last_bit) begin
          rx_data  <= next_word;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  a_r9_pulse_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(capture && last_bit));

endmodule

// File: rtl/spi_emu_master.sv
module spi_emu_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sclk,
  output logic              fs_n,
  output logic              mosi,
  input  logic              miso
);
  spi_emu_pkg::sclk_evt_t evt;
  logic active;
  logic last_bit;

  spi_emu_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(enable), .div(clk_div),
    .sclk(sclk), .evt(evt)
  );

  spi_emu_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(enable), .evt(evt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .mosi(mosi), .active(active), .last_bit(last_bit)
  );

  spi_emu_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(enable), .evt(evt),
    .active(active), .last_bit(last_bit), .miso(miso),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign fs_n = ~active;

  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sclk && fs_n && !mosi && !rx_valid));

  a_r3_fs_fall_with_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_n) |-> $fell(sclk));

  a_r4_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (mosi != $past(mosi))) |-> $fell(sclk));

  a_r5_fs_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $rose(fs_n)) |-> $fell(sclk));

  a_r7_ready_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> sclk);

  a_r9_rx_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($rose(sclk) && !fs_n));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: tb/spi_emu_master_test.sv
module spi_emu_master_test;
  localparam int W  = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, enable = 1'b0, tx_valid = 1'b0, miso = 1'b0;
  logic [DW-1:0] clk_div = '0;
  logic [W-1:0]  tx_data = '0;
  logic          tx_ready, rx_valid, sclk, fs_n, mosi;
  logic [W-1:0]  rx_data;

  spi_emu_master #(.WORD_W(W), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .fs_n(fs_n),
    .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0, cyc = 0;
  int nframes = 0, idle_rises = 0, nrx = 0, word_idx = 0;
  logic [W-1:0] exp_tx[$];
  logic [W-1:0] exp_rx[$];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] reply_of(input int idx);
    return W'((idx * 37 + 3) ^ 8'h5A);
  endfunction

  // slave model and scoreboard monitor
  logic psclk = 1'b1, pfs = 1'b1, pmosi = 1'b0, prxv = 1'b0;
  logic [W-1:0] sh_out, cap, cur_reply;
  int sbits = 0, last_rise = -1;
  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      psclk = 1'b1; pfs = 1'b1; pmosi = 1'b0; sbits = 0; last_rise = -1;
      prxv = 1'b0;
    end else begin
      automatic bit fell = psclk && !sclk;
      automatic bit rose = !psclk && sclk;
      if (pfs && !fs_n) begin
        nframes++;
        chk(fell, "R3 fs_n falls with sclk", fell, 1);
      end
      if (!pfs && fs_n)
        chk(fell && sbits == 0, "R5 fs_n rises on sclk fall after full word", sbits, 0);
      if (mosi !== pmosi)
        chk(fell, "R4 mosi changes only on falling sclk", fell, 1);
      if (rose) begin
        if (fs_n) idle_rises++;
        if (last_rise >= 0)
          chk(cyc - last_rise == 2 * (int'(clk_div) + 1), "R1 sclk period",
              cyc - last_rise, 2 * (int'(clk_div) + 1));
        last_rise = cyc;
      end
      if (rose && !fs_n) begin
        cap = {cap[W-2:0], mosi};
        sbits++;
        if (sbits == W) begin
          sbits = 0;
          if (exp_tx.size() == 0) chk(0, "R4 unexpected word on mosi", cap, 0);
          else begin
            automatic logic [W-1:0] e = exp_tx.pop_front();
            chk(cap == e, "R4 word shifted MSB first", cap, e);
          end
          exp_rx.push_back(cur_reply);
        end
      end
      if (fell && !fs_n) begin
        if (sbits == 0) begin
          cur_reply = reply_of(word_idx++);
          miso   <= cur_reply[W-1];
          sh_out = {cur_reply[W-2:0], 1'b0};
        end else begin
          miso   <= sh_out[W-1];
          sh_out = {sh_out[W-2:0], 1'b0};
        end
      end
      if (rx_valid) begin
        nrx++;
        chk(!prxv, "R9 rx_valid single cycle", prxv, 0);
        chk(!fs_n, "R9 fs_n low with rx_valid", fs_n, 0);
        if (exp_rx.size() == 0) chk(0, "R8 unexpected rx word", rx_data, 0);
        else begin
          automatic logic [W-1:0] e = exp_rx.pop_front();
          chk(rx_data == e, "R8 received word", rx_data, e);
        end
      end
      psclk = sclk; pfs = fs_n; pmosi = mosi; prxv = rx_valid;
    end
  end

  // driver: called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [W-1:0] w);
    tx_data  = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    exp_tx.push_back(w);
    @(negedge clk);
  endtask

  task automatic restart(input int div);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    clk_div = DW'(div);
    enable  = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int f0, r0;
    repeat (3) @(negedge clk);
    chk(sclk && fs_n && !mosi && !tx_ready && !rx_valid, "R2 reset state",
        {sclk, fs_n, mosi, tx_ready, rx_valid}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk && fs_n && !mosi && !tx_ready, "R2 disabled state",
        {sclk, fs_n, mosi, tx_ready}, 4'b1100);

    // idle running clock, no frame without data
    restart(0);
    repeat (40) @(negedge clk);
    chk(nframes == 0, "R7 no frame without tx word", nframes, 0);
    chk(idle_rises >= 2, "R1 sclk runs while idle", idle_rises, 2);

    // back-to-back burst at fastest rate
    f0 = nframes; r0 = nrx;
    send(8'hA3); send(8'h5C); send(8'hF0);
    tx_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(nframes - f0 == 1, "R6 burst shares one frame", nframes - f0, 1);
    chk(nrx - r0 == 3, "R9 one strobe per word", nrx - r0, 3);
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R8 scoreboard drained",
        exp_tx.size() + exp_rx.size(), 0);
    chk(fs_n && !mosi, "R5 idle after burst", {fs_n, mosi}, 2'b10);

    // isolated words with slower clock
    restart(3);
    f0 = nframes; r0 = nrx;
    send(8'h81); tx_valid = 1'b0;
    repeat (150) @(negedge clk);
    send(8'h7E); tx_valid = 1'b0;
    repeat (150) @(negedge clk);
    chk(nframes - f0 == 2, "R5 separate frames for gapped words", nframes - f0, 2);
    chk(nrx - r0 == 2, "R9 strobes for gapped words", nrx - r0, 2);

    // middle divider burst of boundary patterns
    restart(1);
    f0 = nframes; r0 = nrx;
    send(8'h00); send(8'hFF); send(8'h01); send(8'h80);
    tx_valid = 1'b0;
    repeat (120) @(negedge clk);
    chk(nframes - f0 == 1, "R6 four-word burst one frame", nframes - f0, 1);
    chk(nrx - r0 == 4, "R8 four words received", nrx - r0, 4);
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R8 scoreboard drained 2",
        exp_tx.size() + exp_rx.size(), 0);

    // abort mid-word
    send(8'hC6); tx_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(!fs_n, "R10 frame in progress before abort", fs_n, 0);
    r0 = nrx;
    enable = 1'b0;
    @(negedge clk);
    chk(sclk && fs_n && !mosi && !tx_ready, "R10 idle after abort",
        {sclk, fs_n, mosi, tx_ready}, 4'b1100);
    exp_tx.delete(); exp_rx.delete();
    repeat (30) @(negedge clk);
    chk(!rx_valid && nrx == r0, "R10 no strobe for partial word", nrx - r0, 0);

    finish_run();
  end
endmodule